// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder

This block turns one 32-bit instruction word into the control points of a single-cycle datapath. It looks at the 6-bit opcode at the top of the word and the 6-bit function code at the bottom. From these two fields it drives the destination-register select, the ALU operand select, the immediate extender mode, the write-back source select, the memory write strobe, the register-file write strobe, the branch-on-equal select and a 2-bit ALU operation code. The block is purely combinational. The outputs settle within the same cycle as the instruction word and are consumed directly by the register file, ALU, data memory and next-address logic.

Six instructions are recognised: register-form unsigned add and unsigned subtract, OR with a zero-extended immediate, load word, store word, and branch-on-equal. Any other opcode, or a register-form word carrying any other function code, decodes to a safe state in which every output is zero. In that state nothing is written and the sequential next-address path is kept. Decoding runs in two stages. The first stage sorts the opcode into an instruction class and separately qualifies the function code. The second stage maps the class to a control set.

Top module: `mcd_main_decoder`

## Requirements
- R1: Opcode 0x00 with function code 0x21 (unsigned add) gives dst_rd_o=1, alu_src_imm_o=0, ext_sign_o=0, wb_from_mem_o=0, mem_we_o=0, reg_we_o=1, branch_eq_o=0 and alu_op_o=2'b00 (add).
- R2: Opcode 0x00 with function code 0x23 (unsigned subtract) gives the same outputs as R1 except alu_op_o=2'b01 (subtract).
- R3: Opcode 0x0D (OR immediate) gives dst_rd_o=0 (write rt), alu_src_imm_o=1, ext_sign_o=0 (zero extension), wb_from_mem_o=0, mem_we_o=0, reg_we_o=1, branch_eq_o=0 and alu_op_o=2'b10 (OR).
- R4: Opcode 0x23 (load word) gives dst_rd_o=0, alu_src_imm_o=1, ext_sign_o=1, wb_from_mem_o=1, mem_we_o=0, reg_we_o=1, branch_eq_o=0 and alu_op_o=2'b00.
- R5: Opcode 0x2B (store word) gives dst_rd_o=0, alu_src_imm_o=1, ext_sign_o=1, wb_from_mem_o=0, mem_we_o=1, reg_we_o=0, branch_eq_o=0 and alu_op_o=2'b00.
- R6: Opcode 0x04 (branch on equal) gives dst_rd_o=0, alu_src_imm_o=0, ext_sign_o=1, wb_from_mem_o=0, mem_we_o=0, reg_we_o=0, branch_eq_o=1 and alu_op_o=2'b01 (subtract, used for the equality compare).
- R7: Any opcode other than 0x00, 0x0D, 0x23, 0x2B and 0x04 drives every output to zero.
- R8: Opcode 0x00 with any function code other than 0x21 and 0x23 drives every output to zero.
- R9: The outputs depend only on bits [31:26] and, for opcode 0x00, bits [5:0]. Bits [25:6] never change them, and bits [5:0] do not change them for any non-zero opcode.
- R10: reg_we_o and mem_we_o are never both 1, and branch_eq_o=1 never comes with either write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word; opcode in [31:26], function code in [5:0] |
| dst_rd_o | output | 1 | 1 selects rd [15:11] as write register, 0 selects rt [20:16] |
| alu_src_imm_o | output | 1 | 1 feeds the extended immediate to the ALU second operand |
| ext_sign_o | output | 1 | 1 sign-extends imm16, 0 zero-extends |
| wb_from_mem_o | output | 1 | 1 writes memory read data back, 0 writes the ALU result |
| mem_we_o | output | 1 | Data memory write strobe |
| reg_we_o | output | 1 | Register file write strobe |
| branch_eq_o | output | 1 | Selects the taken-branch next address when the ALU reports equal |
| alu_op_o | output | 2 | 00 add, 01 subtract, 10 OR |

## Verification
Several corner cases target decoders that look only at part of the encoding. Load word (0x23) and unsigned subtract (function code 0x23) share a 6-bit value. A decoder that checks the function field without first checking the opcode would decode a load as a subtract, or decode a register-form subtract as a load. Vectors with 0x21 or 0x23 in the low bits of non-register opcodes catch a design whose funct stage leaks into other classes. Exhaustive sweeps of all 64 opcodes and all 64 function codes show whether an unrecognised code leaves a write strobe or the branch select high. Filling the rs, rt, rd and shamt fields with ones and alternating patterns exposes any slice taken from the wrong bits.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

    localparam int OPC_W = 6;
    localparam int FNC_W = 6;

    typedef enum logic [1:0] {
        ALU_ADD = 2'b00,
        ALU_SUB = 2'b01,
        ALU_OR  = 2'b10
    } alu_op_e;

    typedef enum logic [2:0] {
        CLS_NONE  = 3'd0,
        CLS_REG   = 3'd1,
        CLS_ORI   = 3'd2,
        CLS_LOAD  = 3'd3,
        CLS_STORE = 3'd4,
        CLS_BEQ   = 3'd5
    } cls_e;

    typedef struct packed {
        logic    dst_rd;
        logic    src_imm;
        logic    ext_sgn;
        logic    wb_mem;
        logic    mem_we;
        logic    reg_we;
        logic    br_eq;
        alu_op_e alu;
    } ctrl_t;

    localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;

    localparam logic [FNC_W-1:0] FNC_ADDU  = 6'h21;
    localparam logic [FNC_W-1:0] FNC_SUBU  = 6'h23;

    localparam ctrl_t CTRL_SAFE = '{
        dst_rd: 1'b0, src_imm: 1'b0, ext_sgn: 1'b0, wb_mem: 1'b0,
        mem_we: 1'b0, reg_we: 1'b0, br_eq: 1'b0, alu: ALU_ADD
    };

endpackage

// File: rtl/mcd_class_decode.sv
module mcd_class_decode
    import mcd_pkg::*;
#(
    parameter int OP_W = OPC_W
) (
    input  logic [OP_W-1:0] opc_i,
    output cls_e            cls_o
);

    always_comb begin
        unique case (opc_i)
            OPC_REG:   cls_o = CLS_REG;
            OPC_ORI:   cls_o = CLS_ORI;
            OPC_LOAD:  cls_o = CLS_LOAD;
            OPC_STORE: cls_o = CLS_STORE;
            OPC_BEQ:   cls_o = CLS_BEQ;
            default:   cls_o = CLS_NONE;
        endcase
    end

endmodule

// File: rtl/mcd_funct_decode.sv
module mcd_funct_decode
    import mcd_pkg::*;
#(
    parameter int FN_W = FNC_W
) (
    input  logic [FN_W-1:0] fnc_i,
    output logic            fnc_ok_o,
    output alu_op_e         fnc_alu_o
);

    always_comb begin
        unique case (fnc_i)
            FNC_ADDU: begin
                fnc_ok_o  = 1'b1;
                fnc_alu_o = ALU_ADD;
            end
            FNC_SUBU: begin
                fnc_ok_o  = 1'b1;
                fnc_alu_o = ALU_SUB;
            end
            default: begin
                fnc_ok_o  = 1'b0;
                fnc_alu_o = ALU_ADD;
            end
        endcase
    end

endmodule

// File: rtl/mcd_ctrl_gen.sv
module mcd_ctrl_gen
    import mcd_pkg::*;
(
    input  cls_e    cls_i,
    input  logic    fnc_ok_i,
    input  alu_op_e fnc_alu_i,
    output ctrl_t   ctrl_o
);

    always_comb begin
        ctrl_o = CTRL_SAFE;
        unique case (cls_i)
            CLS_REG: begin
                if (fnc_ok_i) begin
                    ctrl_o.dst_rd = 1'b1;
                    ctrl_o.reg_we = 1'b1;
                    ctrl_o.alu    = fnc_alu_i;
                end
            end
            CLS_ORI: begin
                ctrl_o.src_imm = 1'b1;
                ctrl_o.reg_we  = 1'b1;
                ctrl_o.alu     = ALU_OR;
            end
            CLS_LOAD: begin
                ctrl_o.src_imm = 1'b1;
                ctrl_o.ext_sgn = 1'b1;
                ctrl_o.wb_mem  = 1'b1;
                ctrl_o.reg_we  = 1'b1;
            end
            CLS_STORE: begin
                ctrl_o.src_imm = 1'b1;
                ctrl_o.ext_sgn = 1'b1;
                ctrl_o.mem_we  = 1'b1;
            end
            CLS_BEQ: begin
                ctrl_o.ext_sgn = 1'b1;
                ctrl_o.br_eq   = 1'b1;
                ctrl_o.alu     = ALU_SUB;
            end
            default: ctrl_o = CTRL_SAFE;
        endcase
    end

endmodule

// File: rtl/mcd_main_decoder.sv
module mcd_main_decoder
    import mcd_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int OP_W    = OPC_W,
    parameter int FN_W    = FNC_W
) (
    input  logic [INSTR_W-1:0] instr_i,
    output logic               dst_rd_o,
    output logic               alu_src_imm_o,
    output logic               ext_sign_o,
    output logic               wb_from_mem_o,
    output logic               mem_we_o,
    output logic               reg_we_o,
    output logic               branch_eq_o,
    output logic [1:0]         alu_op_o
);

    localparam int OP_LSB = INSTR_W - OP_W;

    logic [OP_W-1:0] opc;
    logic [FN_W-1:0] fnc;
    cls_e            cls;
    logic            fnc_ok;
    alu_op_e         fnc_alu;
    ctrl_t           ctrl;

    assign opc = instr_i[INSTR_W-1:OP_LSB];
    assign fnc = instr_i[FN_W-1:0];

    mcd_class_decode #(.OP_W(OP_W)) u_cls (
        .opc_i (opc),
        .cls_o (cls)
    );

    mcd_funct_decode #(.FN_W(FN_W)) u_fnc (
        .fnc_i     (fnc),
        .fnc_ok_o  (fnc_ok),
        .fnc_alu_o (fnc_alu)
    );

    mcd_ctrl_gen u_gen (
        .cls_i     (cls),
        .fnc_ok_i  (fnc_ok),
        .fnc_alu_i (fnc_alu),
        .ctrl_o    (ctrl)
    );

    assign dst_rd_o      = ctrl.dst_rd;
    assign alu_src_imm_o = ctrl.src_imm;
    assign ext_sign_o    = ctrl.ext_sgn;
    assign wb_from_mem_o = ctrl.wb_mem;
    assign mem_we_o      = ctrl.mem_we;
    assign reg_we_o      = ctrl.reg_we;
    assign branch_eq_o   = ctrl.br_eq;
    assign alu_op_o      = ctrl.alu;

endmodule

// File: rtl/mcd_checker.sv
module mcd_checker (
    input logic [31:0] instr_i,
    input logic        dst_rd_o,
    input logic        alu_src_imm_o,
    input logic        ext_sign_o,
    input logic        wb_from_mem_o,
    input logic        mem_we_o,
    input logic        reg_we_o,
    input logic        branch_eq_o,
    input logic [1:0]  alu_op_o
);

    logic [5:0] op_f;
    logic       op_known;
    assign op_f     = instr_i[31:26];
    assign op_known = (op_f == 6'h00) || (op_f == 6'h0D) || (op_f == 6'h23)
                   || (op_f == 6'h2B) || (op_f == 6'h04);

    always_comb begin
        assert_no_dual_write_R10: assert (!(reg_we_o && mem_we_o));
        assert_branch_no_write_R10: assert (!(branch_eq_o && (reg_we_o || mem_we_o)));
        assert_unknown_safe_R7: assert (op_known || {dst_rd_o, alu_src_imm_o, ext_sign_o,
            wb_from_mem_o, mem_we_o, reg_we_o, branch_eq_o, alu_op_o} == 9'b0);
        assert_load_writes_rt_R4: assert (!wb_from_mem_o || (reg_we_o && !dst_rd_o && alu_src_imm_o));
        assert_rd_uses_busb_R1: assert (!dst_rd_o || (!alu_src_imm_o && reg_we_o && op_f == 6'h00));
        assert_store_sign_ext_R5: assert (!mem_we_o || (ext_sign_o && alu_src_imm_o && op_f == 6'h2B));
        assert_or_zero_ext_R3: assert (alu_op_o != 2'b10 || (!ext_sign_o && op_f == 6'h0D));
    end

endmodule

bind mcd_main_decoder mcd_checker u_mcd_checker (
    .instr_i       (instr_i),
    .dst_rd_o      (dst_rd_o),
    .alu_src_imm_o (alu_src_imm_o),
    .ext_sign_o    (ext_sign_o),
    .wb_from_mem_o (wb_from_mem_o),
    .mem_we_o      (mem_we_o),
    .reg_we_o      (reg_we_o),
    .branch_eq_o   (branch_eq_o),
    .alu_op_o      (alu_op_o)
);

// File: tb/tb_mcd_main_decoder.sv
module tb_mcd_main_decoder;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC       = 14;
    localparam int  WDOG_LIM   = 5000;

    logic        clk = 1'b0;
    logic [31:0] instr;
    logic        dst_rd, src_imm, ext_sgn, wb_mem, mem_we, reg_we, br_eq;
    logic [1:0]  alu_op;
    int          n_chk = 0;
    int          n_err = 0;
    int          cyc   = 0;
    bit          done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcd_main_decoder dut (
        .instr_i       (instr),
        .dst_rd_o      (dst_rd),
        .alu_src_imm_o (src_imm),
        .ext_sign_o    (ext_sgn),
        .wb_from_mem_o (wb_mem),
        .mem_we_o      (mem_we),
        .reg_we_o      (reg_we),
        .branch_eq_o   (br_eq),
        .alu_op_o      (alu_op)
    );

    // {dst_rd, src_imm, ext_sgn, wb_mem, mem_we, reg_we, br_eq, alu_op[1:0]}
    localparam logic [8:0] E_ADDU = 9'b1_0_0_0_0_1_0_00;
    localparam logic [8:0] E_SUBU = 9'b1_0_0_0_0_1_0_01;
    localparam logic [8:0] E_ORI  = 9'b0_1_0_0_0_1_0_10;
    localparam logic [8:0] E_LW   = 9'b0_1_1_1_0_1_0_00;
    localparam logic [8:0] E_SW   = 9'b0_1_1_0_1_0_0_00;
    localparam logic [8:0] E_BEQ  = 9'b0_0_1_0_0_0_1_01;
    localparam logic [8:0] E_NONE = 9'b0;

    localparam logic [31:0] V_INSTR [NVEC] = '{
        32'h0000_0021, 32'h03FF_FFE1, 32'h0000_0023, 32'h02AA_5563,
        32'h3400_0000, 32'h37FF_FFFF, 32'h8C00_0023, 32'h8FFF_FF21,
        32'hAC00_0000, 32'hAD55_AA21, 32'h1000_0000, 32'h13FF_FF23,
        32'h0000_0020, 32'h2000_0021
    };
    localparam logic [8:0] V_EXP [NVEC] = '{
        E_ADDU, E_ADDU, E_SUBU, E_SUBU,
        E_ORI,  E_ORI,  E_LW,   E_LW,
        E_SW,   E_SW,   E_BEQ,  E_BEQ,
        E_NONE, E_NONE
    };
    localparam string V_REQ [NVEC] = '{
        "R1", "R1 R9", "R2", "R2 R9",
        "R3", "R3 R9", "R4 R9", "R4 R9",
        "R5", "R5 R9", "R6", "R6 R9",
        "R8", "R7"
    };

    function automatic logic [8:0] model(input logic [5:0] op, input logic [5:0] fn);
        case (op)
            6'h00:   model = (fn == 6'h21) ? E_ADDU : (fn == 6'h23) ? E_SUBU : E_NONE;
            6'h0D:   model = E_ORI;
            6'h23:   model = E_LW;
            6'h2B:   model = E_SW;
            6'h04:   model = E_BEQ;
            default: model = E_NONE;
        endcase
    endfunction

    task automatic apply_check(input logic [31:0] w, input logic [8:0] exp, input string req);
        logic [8:0] got;
        @(negedge clk);
        instr = w;
        #1;
        got = {dst_rd, src_imm, ext_sgn, wb_mem, mem_we, reg_we, br_eq, alu_op};
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s instr=%h actual=%b expected=%b", req, w, got, exp);
        end
        if (reg_we && mem_we) begin
            n_err++;
            $display("FAIL R10 instr=%h actual=both strobes expected=at most one", w);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG_LIM && !done) begin
            n_err++;
            $display("FAIL watchdog expired actual=%0d cycles expected<=%0d", cyc, WDOG_LIM);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
            $finish;
        end
    end

    initial begin
        instr = 32'h0;
        // all-zero word (shift form, not supported) decodes safe: R8
        apply_check(32'h0000_0000, E_NONE, "R8 zero word");
        for (int i = 0; i < NVEC; i++)
            apply_check(V_INSTR[i], V_EXP[i], V_REQ[i]);
        // every opcode, function bits that would look like addu/subu: R7 R9
        for (int op = 0; op < 64; op++)
            apply_check({op[5:0], 20'hA5A5A, 6'h23}, model(op[5:0], 6'h23), "R7 R9 opcode sweep");
        // every function code under opcode 0: R8 R1 R2
        for (int fn = 0; fn < 64; fn++)
            apply_check({6'h00, 20'hFFFFF, fn[5:0]}, model(6'h00, fn[5:0]), "R8 funct sweep");
        // branch immediately after store, then load, back to back: R10
        apply_check(32'hAC21_0004, E_SW, "R5 R10");
        apply_check(32'h1021_FFFF, E_BEQ, "R6 R10");
        apply_check(32'h8C21_0004, E_LW, "R4 R10");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule